// File: doc/BRIEF.md
# Double-Edge Square-Wave Numerically Controlled Oscillator

This block is a phase-accumulator oscillator that runs in the fast system-clock domain. It produces a square wave meant to drive an external resonant tank. A single-bit square clock can only change on a rising clock edge. This oscillator works out two output levels per clock instead: one for the half-period while the clock is high, and one for the half-period while it is low. A double-data-rate output stage then puts both onto the pin. The pin's edge-timing resolution is therefore half a system clock, which roughly halves the phase jitter that a fixed clock adds to the waveform's edges.

On every rising edge the accumulator adds the tuning word to its phase. In the same cycle it also forms the phase half a step ahead, which is the old phase plus the tuning word shifted right by one. The top bit of the half-step phase becomes the first-half level. The top bit of the full-step phase becomes the second-half level. The accumulator phase is a port, so a downstream phase comparator can read the oscillator's operating point. The output stage is a behavioural model of a DDR register, built from one rising-edge flop and one falling-edge flop whose outputs are combined by XOR.

The block has no control state beyond reset. It is either held in reset or it free-runs. A new tuning word is used at the next rising edge, and the phase carries on from where it was.

Top module: `dual_edge_nco`

## Requirements
- R1: While `rst_n` is low, `phase` is 0, `edge_bits` is 2'b00, and `tank_pin` is low in both halves of the clock, whatever `tune_word` is.
- R2: On each rising edge out of reset, `phase` becomes the previous `phase` plus `tune_word`, modulo 2^PHASE_W.
- R3: `edge_bits[1]` (the first-half level) is registered on each rising edge as the MSB of the previous phase plus floor(`tune_word`/2). For example, `tune_word` = 32'hFFFF_FFFF from phase 0 gives `edge_bits[1]` = 0.
- R4: `edge_bits[0]` (the second-half level) is registered on each rising edge as the MSB of the previous phase plus `tune_word`.
- R5: `tank_pin` shows `edge_bits[1]` during the clock-high half and `edge_bits[0]` during the clock-low half of the cycle that follows their registration, so the pin lags `edge_bits` by one clock.
- R6: A change of `tune_word` takes effect at the very next rising edge and does not reset the phase, so the waveform stays phase-continuous.
- R7: With `tune_word` = 0, `phase` holds its value and `tank_pin` stops toggling one clock after the tuning word reaches zero.
- R8: Starting from reset with a constant `tune_word` below 2^(PHASE_W-1), the number of `tank_pin` level changes over the half-periods of the first N clocks is within ±1 of 2·N·`tune_word`/2^PHASE_W.
- R9: `tune_word` = 32'h8000_0000 from reset gives `edge_bits` of 2'b01, 2'b10, 2'b01, ... on successive clocks, so the pin changes level once per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both of its edges time the pin |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | PHASE_W | Phase increment added on every rising edge |
| phase | output | PHASE_W | Accumulator phase, for a phase detector |
| edge_bits | output | 2 | Registered half-period levels: [1] first half, [0] second half |
| tank_pin | output | 1 | Double-data-rate square-wave output to the tank |

## Verification
The bench builds the block with its default PHASE_W of 32. At that width it can use the extreme tuning words directly. An all-ones word exposes whether the half-step phase rounds down. A word of exactly half the phase range gives one pin change per clock. A word of one produces no transition at all within the run. With 32-bit words, the bench's transition counts and final phases come from plain 64-bit integer arithmetic. The counts are checked over runs of 512 clocks for several ratios between tuning word and phase range.

// File: rtl/dual_edge_nco_pkg.sv
package dual_edge_nco_pkg;

    localparam int unsigned NCO_PHASE_W_DEFAULT = 32;

    // Output levels for the two halves of one system clock.
    typedef struct packed {
        logic first;   // level while clk is high
        logic second;  // level while clk is low
    } half_bits_t;

endpackage

// File: rtl/dual_edge_nco_acc.sv
module dual_edge_nco_acc
    import dual_edge_nco_pkg::*;
#(
    parameter int unsigned PHASE_W = NCO_PHASE_W_DEFAULT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_word,
    output logic [PHASE_W-1:0] phase,
    output half_bits_t         bits
);

    localparam int unsigned MSB = PHASE_W - 1;

    logic [PHASE_W-1:0] half_step;
    logic [PHASE_W-1:0] mid_sum;
    logic [PHASE_W-1:0] end_sum;

    // Phase half a clock ahead (rounded down) and a full clock ahead.
    always_comb begin
        half_step = tune_word >> 1;
        mid_sum   = phase + half_step;
        end_sum   = phase + tune_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase       <= '0;
            bits.first  <= 1'b0;
            bits.second <= 1'b0;
        end else begin
            phase       <= end_sum;
            bits.first  <= mid_sum[MSB];
            bits.second <= end_sum[MSB];
        end
    end

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase == $past(phase) + $past(tune_word))) // R2
        else $error("phase did not advance by the tuning word");

    AST_FIRST_HALF_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bits.first == (($past(phase) + ($past(tune_word) >> 1)) >> MSB))) // R3
        else $error("first-half level does not follow the half-step phase");

    AST_ZERO_TUNE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(tune_word) == '0)) |-> $stable(phase)) // R7
        else $error("phase moved with a zero tuning word");

endmodule

// File: rtl/dual_edge_nco_ddr_out.sv
module dual_edge_nco_ddr_out (
    input  logic clk,
    input  logic rst_n,
    input  logic d_first,
    input  logic d_second,
    output logic pin
);

    logic pos_q;
    logic neg_q;
    logic second_hold;

    // Rising-edge side: loads the first-half level and holds the second.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q       <= 1'b0;
            second_hold <= 1'b0;
        end else begin
            pos_q       <= d_first ^ neg_q;
            second_hold <= d_second;
        end
    end

    // Falling-edge side: swaps the pin to the held second-half level.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= second_hold ^ pos_q;
        end
    end

    assign pin = pos_q ^ neg_q;

    AST_PIN_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pin == $past(d_second))) // R5
        else $error("clock-low half of the pin does not carry the second level");

    AST_PIN_HIGH_HALF: assert property (@(negedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pin == $past(d_first))) // R5
        else $error("clock-high half of the pin does not carry the first level");

endmodule

// File: rtl/dual_edge_nco.sv
module dual_edge_nco
    import dual_edge_nco_pkg::*;
#(
    parameter int unsigned PHASE_W = NCO_PHASE_W_DEFAULT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_word,
    output logic [PHASE_W-1:0] phase,
    output logic [1:0]         edge_bits,
    output logic               tank_pin
);

    half_bits_t acc_bits;

    dual_edge_nco_acc #(
        .PHASE_W (PHASE_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tune_word (tune_word),
        .phase     (phase),
        .bits      (acc_bits)
    );

    dual_edge_nco_ddr_out u_ddr (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_first  (acc_bits.first),
        .d_second (acc_bits.second),
        .pin      (tank_pin)
    );

    assign edge_bits = {acc_bits.first, acc_bits.second};

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (phase == '0 && edge_bits == 2'b00 && !tank_pin)) // R1
        else $error("outputs not quiet in reset");

endmodule

// File: tb/test_dual_edge_nco.sv
module test_dual_edge_nco;

    localparam int PW      = 32;
    localparam int RUN_N   = 512;
    localparam int TAB_LEN = 6;
    localparam logic [31:0] TAB_TW [TAB_LEN] = '{
        32'h0100_0000, 32'h0555_5555, 32'h1234_5678,
        32'h7FFF_FFFF, 32'h0000_0001, 32'h4000_0000
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] tune_word = '0;
    logic [PW-1:0] phase;
    logic [1:0]    edge_bits;
    logic          tank_pin;

    int checks = 0;
    int errors = 0;

    logic [31:0] acc_m;
    logic [1:0]  prev_b;
    logic        last_pin;
    int          trans;
    int          mism;

    always #4 clk = ~clk;

    dual_edge_nco #(.PHASE_W(PW)) i_dual_edge_nco (
        .clk       (clk),
        .rst_n     (rst_n),
        .tune_word (tune_word),
        .phase     (phase),
        .edge_bits (edge_bits),
        .tank_pin  (tank_pin)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic note_pin();
        if (tank_pin !== last_pin) trans++;
        last_pin = tank_pin;
    endtask

    // Hold reset for a few clocks with a nonzero word, check quiet outputs (R1).
    task automatic apply_reset(input logic [31:0] tw_during);
        rst_n = 1'b0;
        tune_word = tw_during;
        repeat (3) @(negedge clk);
        #2;
        check("R1", "phase in reset", phase, 0);
        check("R1", "edge_bits in reset", edge_bits, 0);
        check("R1", "pin low half in reset", tank_pin, 0);
        @(posedge clk); #2;
        check("R1", "pin high half in reset", tank_pin, 0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        #1;
        acc_m = '0; prev_b = 2'b00; last_pin = 1'b0; trans = 0; mism = 0;
    endtask

    // One clock with word tw; compares phase, bits and both pin halves (R2 R3 R4 R5).
    task automatic step(input logic [31:0] tw);
        logic [31:0] mid;
        logic [31:0] fin;
        logic [1:0]  exp_b;
        tune_word = tw;
        @(posedge clk); #2;
        if (tank_pin !== prev_b[1]) mism++;
        note_pin();
        mid   = acc_m + (tw >> 1);
        fin   = acc_m + tw;
        exp_b = {mid[31], fin[31]};
        acc_m = fin;
        if (phase !== acc_m || edge_bits !== exp_b) mism++;
        @(negedge clk); #2;
        if (tank_pin !== prev_b[0]) mism++;
        note_pin();
        prev_b = exp_b;
    endtask

    initial begin : watchdog
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // Table of tuning words walked by one loop (R2 R3 R4 R5 R8).
        for (int k = 0; k < TAB_LEN; k++) begin
            longint exp_tr;
            longint diff;
            apply_reset(32'hDEAD_BEEF);
            for (int s = 0; s <= RUN_N; s++) step(TAB_TW[k]);
            exp_tr = longint'((64'(RUN_N) * 64'(TAB_TW[k])) >> 31);
            check("R2", "final phase", phase,
                  longint'(32'(64'(RUN_N + 1) * 64'(TAB_TW[k]))));
            check("R3 R4 R5", "per-cycle mismatches", mism, 0);
            diff = longint'(trans) - exp_tr;
            checks++;
            if (diff > 1 || diff < -1) begin
                errors++;
                $display("FAIL R8 transitions tw=%0h actual=%0d expected=%0d",
                         TAB_TW[k], trans, exp_tr);
            end
        end

        // R6: switch words mid-run, phase continues without restart.
        apply_reset(32'h0);
        for (int s = 0; s < 10; s++) step(32'h0234_5678);
        for (int s = 0; s < 10; s++) step(32'h1111_0001);
        check("R6", "phase after word change", phase,
              longint'(32'(10 * 64'h0234_5678 + 10 * 64'h1111_0001)));
        check("R6", "per-cycle mismatches across change", mism, 0);

        // R7: zero word freezes phase and pin.
        apply_reset(32'h0);
        for (int s = 0; s < 5; s++) step(32'h1800_0000);
        step(32'h0);
        step(32'h0);
        trans = 0;
        for (int s = 0; s < 20; s++) step(32'h0);
        check("R7", "phase frozen", phase, 32'h7800_0000);
        check("R7", "pin transitions with zero word", trans, 0);

        // R9: half-range word alternates the two levels every clock.
        apply_reset(32'h0);
        step(32'h8000_0000);
        check("R9", "edge_bits clock 1", edge_bits, 2'b01);
        step(32'h8000_0000);
        check("R9", "edge_bits clock 2", edge_bits, 2'b10);
        step(32'h8000_0000);
        check("R9", "edge_bits clock 3", edge_bits, 2'b01);
        check("R5", "pin low half shows clock-2 second level", tank_pin, 0);
        check("R9", "per-cycle mismatches", mism, 0);

        // R3 / R4: all-ones word, half step must round down.
        apply_reset(32'h0);
        step(32'hFFFF_FFFF);
        check("R3", "first-half level rounds down", edge_bits[1], 0);
        check("R4", "second-half level", edge_bits[0], 1);
        step(32'hFFFF_FFFF);
        check("R4", "second-half level clock 2", edge_bits[0], 1);
        check("R5", "pin low half after clock 2", tank_pin, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule